// File: doc/BRIEF.md
# Phase-Error Width Resistance Selector

This block sits next to a PLL phase comparator. It measures how long each phase-error pulse lasts and picks one of four charge-pump output-resistance levels from that width. A wide pulse means the loop is far from lock, so the block picks a low resistance for fast pull-in. A narrow pulse means the loop is near lock, so it picks a high resistance for a quiet loop.

The width is counted in periods of a detection clock. That clock is the oscillator clock divided by 2, 4, 8 or 16, and a 2-bit select chooses the ratio. Measurement runs only while the enable input is high. The measured level drives the output only under three conditions together: auto mode is on, the output is configured as the comparator output, and the pulse-output mode is off. In every other case the output follows a 2-bit fixed setting.

Top module: `pe_res_sel`

## Requirements
- R1: After reset, with measurement and auto selection active, `res_code_o` is 2'b00, the 100 kΩ level.
- R2: A pulse held high for W clock cycles at `perr_i` yields code min(3, floor(W/N)), where N is the division ratio. The codes mean 2'b00 = 100 kΩ, 2'b01 = 50 kΩ, 2'b10 = 5 kΩ and 2'b11 = 0 kΩ.
- R3: `clk_sel_i` sets N as follows: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16.
- R4: The width count saturates at 3, so any pulse of 3N cycles or more yields 2'b11.
- R5: The measured code updates only at the end of a pulse. It becomes visible on the third rising clock edge after the first edge that samples `perr_i` low. It is held unchanged while the next pulse is in progress.
- R6: With `auto_i` = 0, `res_code_o` equals `fixed_res_i`.
- R7: With `pulse_mode_i` = 1, `res_code_o` equals `fixed_res_i`, whatever `auto_i` is.
- R8: With `cmp_mode_i` = 0, `res_code_o` equals `fixed_res_i`.
- R9: With `meas_en_i` = 0, pulses are ignored and the measured code is forced to 2'b00.
- R10: A change of `clk_sel_i` clears the divider and the width count. A pulse that spans the change is therefore measured only from the change onwards.
- R11: Each pulse is measured on its own. The count restarts at every rising edge of the synchronized pulse, and the divider phase restarts with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| perr_i | input | 1 | Phase-error pulse, asynchronous |
| meas_en_i | input | 1 | Enable for width measurement |
| auto_i | input | 1 | Measured level drives the output |
| clk_sel_i | input | 2 | Detection clock ratio select |
| fixed_res_i | input | 2 | Fixed resistance code |
| pulse_mode_i | input | 1 | Pulse-output mode, has priority |
| cmp_mode_i | input | 1 | Output configured as comparator output |
| res_code_o | output | 2 | Selected resistance code |

## Verification
The bench sweeps pulse widths of N-1, N, 2N, 3N and 10N for every ratio. A threshold that is off by one period, or a ratio decoded wrongly, shows up as a code one step away from the expected one, and a counter that wraps instead of saturating turns 10N into a small code. It checks the output two edges and three edges after a pulse ends, and also in the middle of the next pulse. A design that latches early or updates the code mid-pulse fails these checks. It also changes the ratio partway through a long pulse and sends a short pulse after a long one. A design that does not clear the count on either event reports a low-resistance code where 100 kΩ or 50 kΩ is expected.

// File: rtl/pe_res_pkg.sv
package pe_res_pkg;
  localparam int unsigned CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t RES_100K = 2'd0;
  localparam code_t RES_50K  = 2'd1;
  localparam code_t RES_5K   = 2'd2;
  localparam code_t RES_0K   = 2'd3;
endpackage

// File: rtl/pe_sync.sv
module pe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];

  // R11: synchronized pulse rises only after the input was high STAGES edges earlier
  p_sync_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(d_i, STAGES));
endmodule

// File: rtl/pe_det_div.sv
module pe_det_div #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned DIV_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  // ratio is 2 << sel; last count of the period is ratio-1
  assign lim    = DIV_W'((32'd2 << sel_i) - 32'd1);
  assign tick_o = (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 div_q <= '0;
    else if (!en_i || restart_i) div_q <= '0;
    else if (tick_o)             div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end

  // R3: ratio is at least 2, so ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pe_width_meas.sv
module pe_width_meas
  import pe_res_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  clr_i,
  input  logic  perr_s_i,
  input  logic  tick_i,
  output logic  rise_o,
  output code_t code_o
);
  localparam code_t CNT_MAX = RES_0K;

  logic  perr_q;
  code_t cnt_q, cnt_nxt, code_q;
  logic  fall, cnt_inc;

  assign rise_o  = perr_s_i & ~perr_q;
  assign fall    = ~perr_s_i & perr_q;
  // count ticks over the synchronized pulse, including its last cycle
  assign cnt_inc = perr_q & tick_i & (cnt_q != CNT_MAX);
  assign cnt_nxt = cnt_q + code_t'(cnt_inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q <= 1'b0;
      cnt_q  <= RES_100K;
      code_q <= RES_100K;
    end else if (!en_i) begin
      perr_q <= 1'b0;
      cnt_q  <= RES_100K;
      code_q <= RES_100K;
    end else begin
      perr_q <= perr_s_i;
      if (rise_o || clr_i) cnt_q <= RES_100K;
      else                 cnt_q <= cnt_nxt;
      if (fall)            code_q <= clr_i ? RES_100K : cnt_nxt;
    end
  end

  assign code_o = code_q;

  // R5: code moves only when a pulse ends
  p_code_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fall) |=> $stable(code_q));
  // R4: saturated count stays saturated during a pulse
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rise_o && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  // R9: disabled measurement forces the highest resistance
  p_dis_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (code_q == RES_100K));
endmodule

// File: rtl/pe_res_sel.sv
module pe_res_sel
  import pe_res_pkg::*;
#(
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             perr_i,
  input  logic             meas_en_i,
  input  logic             auto_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic [1:0]       fixed_res_i,
  input  logic             pulse_mode_i,
  input  logic             cmp_mode_i,
  output logic [1:0]       res_code_o
);
  logic             perr_s, rise, tick, sel_chg, auto_path;
  logic [SEL_W-1:0] sel_q;
  code_t            meas_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= clk_sel_i;
  end
  assign sel_chg = (clk_sel_i != sel_q);

  pe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(perr_i), .q_o(perr_s)
  );

  pe_det_div #(.SEL_W(SEL_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (meas_en_i),
    .restart_i(rise | sel_chg),
    .sel_i    (clk_sel_i),
    .tick_o   (tick)
  );

  pe_width_meas u_meas (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (meas_en_i),
    .clr_i   (sel_chg),
    .perr_s_i(perr_s),
    .tick_i  (tick),
    .rise_o  (rise),
    .code_o  (meas_code)
  );

  // pulse-output mode wins; auto only in comparator output mode
  assign auto_path  = auto_i & cmp_mode_i & ~pulse_mode_i;
  assign res_code_o = auto_path ? meas_code : fixed_res_i;

  // R7: pulse-output mode always yields the fixed setting
  p_pulse_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_mode_i |-> (res_code_o == fixed_res_i));
  // R8: non-comparator output mode yields the fixed setting
  p_cmp_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_mode_i |-> (res_code_o == fixed_res_i));
endmodule

// File: tb/tb_pe_res_sel.sv
module tb_pe_res_sel;
  logic       clk = 1'b0;
  logic       rst_ni, perr, en, auto_m, pmode, cmode;
  logic [1:0] sel, fixed;
  logic [1:0] res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pe_res_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .perr_i(perr), .meas_en_i(en),
    .auto_i(auto_m), .clk_sel_i(sel), .fixed_res_i(fixed),
    .pulse_mode_i(pmode), .cmp_mode_i(cmode), .res_code_o(res)
  );

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(input int w, input int n);
    return (w / n > 3) ? 2'd3 : 2'(w / n);
  endfunction

  task automatic pulse(input int w);
    perr = 1'b1;
    repeat (w) @(negedge clk);
    perr = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(res, 2'd0, "R1 reset code");
  endtask

  task automatic t_widths;
    for (int s = 0; s < 4; s++) begin
      int n;
      n = 2 << s;
      sel = 2'(s);
      repeat (3) @(negedge clk);
      pulse(n - 1); chk(res, exp_code(n - 1, n), "R2 R3 width N-1");
      pulse(n);     chk(res, exp_code(n, n),     "R2 R3 width N");
      pulse(2 * n); chk(res, exp_code(2 * n, n), "R2 R3 width 2N");
      pulse(3 * n); chk(res, exp_code(3 * n, n), "R2 R4 width 3N");
      pulse(10 * n); chk(res, 2'd3,             "R4 saturation 10N");
    end
  endtask

  task automatic t_hold;
    sel = 2'd0;
    repeat (3) @(negedge clk);
    pulse(6);
    chk(res, 2'd3, "R5 first pulse");
    perr = 1'b1;
    repeat (4) @(negedge clk);
    chk(res, 2'd3, "R5 held mid pulse");
    perr = 1'b0;
    repeat (2) @(negedge clk);
    chk(res, 2'd3, "R5 not yet updated");
    @(negedge clk);
    chk(res, 2'd2, "R5 updated third edge");
    repeat (3) @(negedge clk);
  endtask

  task automatic t_indep;
    sel = 2'd0;
    pulse(8);
    pulse(2);
    chk(res, 2'd1, "R11 short after long");
  endtask

  task automatic t_fixed;
    sel = 2'd0;
    pulse(6);
    auto_m = 1'b0; fixed = 2'd2; #1;
    chk(res, 2'd2, "R6 auto off");
    fixed = 2'd1; #1;
    chk(res, 2'd1, "R6 auto off follows");
    auto_m = 1'b1; pmode = 1'b1; #1;
    chk(res, 2'd1, "R7 pulse mode priority");
    pmode = 1'b0; cmode = 1'b0; #1;
    chk(res, 2'd1, "R8 not comparator mode");
    cmode = 1'b1; #1;
    chk(res, 2'd3, "R6 measured restored");
    @(negedge clk);
  endtask

  task automatic t_enable;
    sel = 2'd0;
    pulse(6);
    en = 1'b0;
    @(negedge clk);
    pulse(6);
    chk(res, 2'd0, "R9 disabled ignores pulse");
    en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_selchg;
    sel = 2'd0;
    repeat (3) @(negedge clk);
    perr = 1'b1;
    repeat (6) @(negedge clk);
    sel = 2'd3;
    repeat (6) @(negedge clk);
    perr = 1'b0;
    repeat (5) @(negedge clk);
    chk(res, 2'd0, "R10 select change clears count");
  endtask

  initial begin
    rst_ni = 1'b0; perr = 1'b0; en = 1'b1; auto_m = 1'b1;
    pmode = 1'b0; cmode = 1'b1; sel = 2'd0; fixed = 2'd3;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_widths();
    t_hold();
    t_indep();
    t_fixed();
    t_enable();
    t_selchg();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule